// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the serial front end of a small register bank. It oversamples the two-wire bus lines with the system clock and filters out short glitches. It finds START, repeated START and STOP conditions and checks a seven-bit device identity. Five of the identity bits are fixed and two come from board-strap inputs. After the identity, the block takes a register address, and then either stores one data byte or streams register contents back to the master.

The bank behind the block sees a plain synchronous port. A pointer selects the register. A one-cycle write strobe carries the data byte. The bank returns read data for the selected register. The block never drives the data line high. Its only output to the pad is an active-high pull-low enable, which is used for acknowledges and for the zero bits of read data.

While a power-up busy input is asserted, the block does not start transactions. A START or STOP that arrives in the middle of a byte cancels the byte in progress.

Top module: `i2c_regport_slave`

## Requirements
- R1: A level change on either bus line is accepted only after it has held for FILT_LEN consecutive system clocks. A pulse of FILT_LEN-1 clocks or less is ignored.
- R2: A START is a falling SDA while SCL is high. A STOP is a rising SDA while SCL is high. Data bits are taken on rising SCL, and the slave changes its own output only while SCL is low.
- R3: The identity byte is sent MSB first. Its bits [7:3] must be 10100, its bits [2:1] must equal pin_sel[1:0], and bit 0 is the direction (1 = read, 0 = write). On a match the slave pulls SDA low in the ninth clock. On a mismatch it leaves SDA released for the rest of the transaction.
- R4: The byte that follows a write identity is acknowledged and becomes the register pointer. The pointer is visible on reg_addr.
- R5: The next byte is acknowledged and written with exactly one reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. Any further bytes before STOP are neither acknowledged nor written.
- R6: After a read identity, the slave sends reg_rdata for the current pointer, MSB first, one bit per SCL low phase.
- R7: The pointer advances by one after each byte sent. After 0Fh it goes to 00h.
- R8: The master sends a low in the ninth clock to ask for another byte. A high there makes the slave release SDA until the next START.
- R9: No START is accepted while busy_i is high, so the slave stays silent.
- R10: A START in the middle of a byte restarts identity matching. A STOP returns the slave to idle with SDA released.
- R11: sda_oe changes only while the filtered SCL is low.
- R12: After reset, sda_oe and reg_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (wired-AND of all drivers) |
| pin_sel | input | 2 | Strap bits compared with identity bits [2:1] |
| busy_i | input | 1 | Power-up busy; START is ignored while high |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data byte |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data of the register at reg_addr |

## Verification
Each bus line passes through two synchroniser stages, the FILT_LEN hold counter and one edge register. As a result, each output of the slave follows the SCL edge that causes it by about FILT_LEN+3 system clocks. The bench uses SCL quarter-phases of 12 clocks, well longer than this delay. It samples the acknowledge and read bits in the middle of the SCL high phase, and it checks reg_addr and the bank contents only after the closing STOP has settled. Release after a NACK is checked one quarter-phase after the SCL fall, once the slave's own fall has been seen.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_IGNORE, S_DEVID, S_ACK_WID, S_ACK_RID,
    S_ADDR, S_ACK_ADDR, S_WDATA, S_ACK_DATA, S_TX, S_MACK
  } slv_state_t;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; filt_o <= 1'b1; run <= '0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 != filt_o) begin
        if (run == CW'(FILT_LEN - 1)) begin
          filt_o <= s2;
          run <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f; sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2cs_pkg::*;
#(
  parameter int          FILT_LEN  = 3,
  parameter int          DW        = 8,
  parameter logic [4:0]  ID_PREFIX = 5'b10100,
  parameter logic [7:0]  WRAP_AT   = 8'h0F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    pin_sel,
  input  logic          busy_i,
  output logic          sda_oe,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int BCW = $clog2(DW + 1);

  logic [1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, ev_start, ev_stop;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst(rst), .raw_i(raw_lines[g]), .filt_o(filt_lines[g])
    );
  end
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2cs_bus_events u_ev (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  slv_state_t       st;
  logic [BCW-1:0]   cnt;
  logic [DW-1:0]    sh, tx, ptr;
  logic             mack;
  logic             id_match;
  logic             rx_state;

  assign id_match = (sh[7:3] == ID_PREFIX) && (sh[2:1] == pin_sel);
  assign rx_state = (st == S_DEVID) || (st == S_ADDR) || (st == S_WDATA);
  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      mack <= 1'b0; sda_oe <= 1'b0; reg_we <= 1'b0; reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (ev_stop) begin
        st <= S_IDLE; sda_oe <= 1'b0; cnt <= '0;
      end else if (ev_start && !busy_i) begin
        st <= S_DEVID; sda_oe <= 1'b0; cnt <= '0;
      end else if (rx_state) begin
        if (scl_rise && cnt != BCW'(DW)) begin
          sh  <= {sh[DW-2:0], sda_f};
          cnt <= cnt + 1'b1;
        end else if (scl_fall && cnt == BCW'(DW)) begin
          cnt <= '0;
          unique case (st)
            S_DEVID: begin
              if (id_match) begin
                sda_oe <= 1'b1;
                st <= sh[0] ? S_ACK_RID : S_ACK_WID;
              end else begin
                st <= S_IGNORE;
              end
            end
            S_ADDR: begin
              ptr <= sh; sda_oe <= 1'b1; st <= S_ACK_ADDR;
            end
            default: begin
              reg_we <= 1'b1; reg_wdata <= sh; sda_oe <= 1'b1; st <= S_ACK_DATA;
            end
          endcase
        end
      end else begin
        unique case (st)
          S_ACK_WID:  if (scl_fall) begin sda_oe <= 1'b0; st <= S_ADDR; end
          S_ACK_ADDR: if (scl_fall) begin sda_oe <= 1'b0; st <= S_WDATA; end
          S_ACK_DATA: if (scl_fall) begin sda_oe <= 1'b0; st <= S_IGNORE; end
          S_ACK_RID: if (scl_fall) begin
            tx <= reg_rdata; sda_oe <= ~reg_rdata[DW-1]; cnt <= '0; st <= S_TX;
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == BCW'(DW)) begin
                sda_oe <= 1'b0; cnt <= '0; st <= S_MACK;
                ptr <= (ptr == WRAP_AT) ? '0 : ptr + 1'b1;
              end else begin
                tx <= tx << 1; sda_oe <= ~tx[DW-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_f;
            else if (scl_fall) begin
              if (mack) begin
                tx <= reg_rdata; sda_oe <= ~reg_rdata[DW-1]; st <= S_TX;
              end else begin
                st <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       busy_i,
  input slv_state_t st,
  input logic       sda_oe,
  input logic       reg_we
);
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f);

  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  a_r5_we_with_ack: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> sda_oe);

  a_r9_busy_idle: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && busy_i) |=> st == S_IDLE);

  a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
    st == S_IDLE |-> !sda_oe);
endmodule

bind i2c_regport_slave i2cs_checker u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .busy_i(busy_i),
  .st(st), .sda_oe(sda_oe), .reg_we(reg_we)
);

// File: tb/i2c_regport_slave_test.sv
module i2c_regport_slave_test;
  localparam int Q = 12;
  localparam logic [1:0] PINS = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] bank [0:255];
  logic [7:0] expm [0:255];
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_regport_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .pin_sel(PINS),
    .busy_i(busy), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

  function automatic logic [7:0] idb(input logic [4:0] pre, input logic [1:0] p, input logic rw);
    return {pre, p, rw};
  endfunction
  function automatic logic [7:0] nxt(input logic [7:0] a);
    return (a == 8'h0F) ? 8'h00 : a + 8'h01;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_bit(input logic b, input bit glitch, output logic got);
    wq(); sda_m = b;
    if (glitch) begin scl_m = 1'b1; @(negedge clk); @(negedge clk); scl_m = 1'b0; end
    wq(); scl_m = 1'b1; wq(); got = sda_line; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], glitch && i == 4, g);
    bus_bit(1'b1, 1'b0, g);
    ack = ~g;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, 1'b0, g); d[i] = g; end
    bus_bit(~give_ack, 1'b0, g);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit extra,
                          input bit glitch, input string req);
    logic k;
    bus_start();
    send_byte(idb(5'b10100, PINS, 1'b0), glitch, k); chk({req, " id ack (R3)"}, k, 1);
    send_byte(a, 1'b0, k);                           chk({req, " addr ack (R4)"}, k, 1);
    send_byte(d, 1'b0, k);                           chk({req, " data ack (R5)"}, k, 1);
    if (extra) begin
      send_byte(~d, 1'b0, k); chk("R5 second data byte not acked", k, 0);
    end
    bus_stop();
    expm[a] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string req);
    logic k; logic [7:0] d, p;
    bus_start();
    send_byte(idb(5'b10100, PINS, 1'b0), 1'b0, k); chk({req, " id ack (R3)"}, k, 1);
    send_byte(a, 1'b0, k);                         chk({req, " addr ack (R4)"}, k, 1);
    bus_start();
    send_byte(idb(5'b10100, PINS, 1'b1), 1'b0, k); chk({req, " read id ack (R6)"}, k, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk({req, " read data (R6 R7)"}, d, expm[p]);
      p = nxt(p);
    end
    wq(); chk("R8 SDA released after NACK", sda_oe, 0);
    bus_stop();
    chk("R7 pointer after read", reg_addr, p);
  endtask

  initial begin
    logic k;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin bank[i] = 8'(i * 7 + 3); expm[i] = 8'(i * 7 + 3); end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset sda_oe", sda_oe, 0);
    chk("R12 reset reg_we", reg_we, 0);

    do_write(8'h05, 8'hA5, 0, 0, "R5 write");
    chk("R4 pointer after write", reg_addr, 8'h05);
    do_read(8'h05, 1, "R6 single read");
    do_read(8'h0E, 4, "R7 wrap read");
    do_write(8'h03, 8'h3C, 1, 0, "R5 extra byte");
    do_read(8'h03, 2, "R5 extra not written");
    do_write(8'h09, 8'h96, 0, 1, "R1 glitch");
    do_read(8'h09, 1, "R1 glitch read");

    bus_start();
    send_byte(idb(5'b10110, PINS, 1'b0), 0, k); chk("R3 wrong prefix silent", k, 0);
    send_byte(8'h01, 0, k);                     chk("R3 ignored after mismatch", k, 0);
    bus_stop();
    bus_start();
    send_byte(idb(5'b10100, ~PINS, 1'b0), 0, k); chk("R3 wrong pins silent", k, 0);
    bus_stop();

    busy = 1'b1;
    bus_start();
    send_byte(idb(5'b10100, PINS, 1'b0), 0, k); chk("R9 busy start ignored", k, 0);
    bus_stop();
    busy = 1'b0;

    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b1, 0, k);
    bus_start();
    send_byte(idb(5'b10100, PINS, 1'b0), 0, k); chk("R10 restart id ack", k, 1);
    send_byte(8'h0C, 0, k);                     chk("R10 addr ack", k, 1);
    bus_stop();
    chk("R10 released after STOP", sda_oe, 0);
    chk("R2 pointer from aborted-then-restarted write", reg_addr, 8'h0C);

    for (int t = 0; t < 10; t++) begin
      logic [7:0] a, d;
      a = 8'($urandom_range(0, 15));
      d = 8'($urandom);
      do_write(a, d, 0, 0, "R5 random write");
      do_read(a, 1 + int'($urandom_range(0, 2)), "R6 random read");
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule